// File: doc/BRIEF.md
# Condition-Gated Flag-Setting ALU

This block is the integer data-processing stage of a small processor core. Each clock it takes two 32-bit operands, an operation select, a condition code, a set-flags control and the current N, Z, C, V flags, together with the carry bit from an upstream shifter. It first checks whether the condition code holds on the current flags. If the condition fails, the operation is squashed: no result is written and the flags are left as they were.

When the condition holds, the block computes an arithmetic or logical result. It also computes the new flags. These are written when set-flags is high, or always for the compare and test forms, which never write a result. All outputs are registered, so a result appears one clock after its inputs are sampled. The surrounding core owns the register file and the flag register. It takes `flags_out` under `flags_we` and `result` under `result_we`.

Flags are packed as bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V on both `flags_in` and `flags_out`.

Top module: `cond_alu`

## Requirements
- R1: Condition codes are decoded as follows. 0000 needs Z=1, and 0001 needs Z=0. 0010 needs C=1, and 0011 needs C=0. 0100 needs N=1, and 0101 needs N=0. 0110 needs V=1, and 0111 needs V=0. 1000 needs C=1 and Z=0. 1001 needs C=0 or Z=1. 1010 needs N=V, and 1011 needs N!=V. 1100 needs Z=0 and N=V. 1101 needs Z=1 or N!=V. 1110 always passes. 1111 never passes.
- R2: When the condition fails, the next cycle shows `result_we`=0, `flags_we`=0, `result`=0, and `flags_out` equal to the sampled `flags_in`.
- R3: Arithmetic operations use these opcodes. 0100 gives a+b, and 0101 gives a+b+C. 0010 gives a-b, and 0110 gives a-b-(NOT C). 0011 gives b-a, and 0111 gives b-a-(NOT C). All results are modulo 2^32.
- R4: For additions, the new C is the carry out of bit 31. For subtractions, the new C is 1 exactly when no borrow occurs.
- R5: For arithmetic operations, the new V is 1 exactly when the signed result does not fit in 32 bits. N is the result's bit 31, and Z is 1 when the result is zero.
- R6: Logical operations use these opcodes. 0000 gives a AND b, and 0001 gives a XOR b. 1100 gives a OR b, and 1110 gives a AND NOT b. 1101 passes b through, and 1111 gives NOT b.
- R7: Logical operations set N and Z from the result and take C from `shift_cy`. They keep V from `flags_in`.
- R8: The flag-only opcodes are 1000 (a AND b), 1001 (a XOR b), 1010 (a-b) and 1011 (a+b). When their condition passes, `flags_we`=1 whatever `set_flags` is, and `result_we`=0 with `result`=0.
- R9: A result-writing operation with a passing condition and `set_flags`=0 gives `flags_we`=0 and `flags_out` equal to `flags_in`.
- R10: While `rst_n` is low, all outputs are 0.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opsel | input | 4 | Operation select |
| cond | input | 4 | Condition code |
| set_flags | input | 1 | Request a flag update from a result-writing operation |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_cy | input | 1 | Carry from the operand shifter, used by logical operations |
| result | output | 32 | Registered result, zero when not written |
| result_we | output | 1 | Result write enable |
| flags_out | output | 4 | Registered flags {N,Z,C,V} |
| flags_we | output | 1 | Flag write enable |

## Verification
The assertions assume that every input is a known value on each clock edge once reset is released. They also assume that `flags_in` is the flag state the caller wants tested in that same cycle. The bench drives every input on the falling edge from defined values and never leaves one floating. It sweeps all 16 condition codes against all 16 flag patterns, then drives directed operand corner values and a long pseudo-random mix. It compares every output with a behavioural integer model on every cycle.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opsel,
  input  logic [3:0]   cond,
  input  logic         set_flags,
  input  logic [3:0]   flags_in,
  input  logic         shift_cy,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags_out,
  output logic         flags_we
);
  localparam int MSB = W - 1;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_in;

  logic pass;
  always_comb begin
    case (cond)
      4'h0: pass = fz;
      4'h1: pass = !fz;
      4'h2: pass = fc;
      4'h3: pass = !fc;
      4'h4: pass = fn;
      4'h5: pass = !fn;
      4'h6: pass = fv;
      4'h7: pass = !fv;
      4'h8: pass = fc && !fz;
      4'h9: pass = !fc || fz;
      4'hA: pass = (fn == fv);
      4'hB: pass = (fn != fv);
      4'hC: pass = !fz && (fn == fv);
      4'hD: pass = fz || (fn != fv);
      4'hE: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  logic flag_only;
  assign flag_only = (opsel[3:2] == 2'b10);

  logic         arith;
  logic [W-1:0] ax, ay;
  logic         acin;
  always_comb begin
    arith = 1'b1;
    ax    = op_a;
    ay    = op_b;
    acin  = 1'b0;
    case (opsel)
      4'h4, 4'hB: ;
      4'h5:       acin = fc;
      4'h2, 4'hA: begin ay = ~op_b; acin = 1'b1; end
      4'h6:       begin ay = ~op_b; acin = fc;   end
      4'h3:       begin ax = op_b; ay = ~op_a; acin = 1'b1; end
      4'h7:       begin ax = op_b; ay = ~op_a; acin = fc;   end
      default:    arith = 1'b0;
    endcase
  end

  logic [W:0] sum;
  assign sum = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, acin};

  logic [W-1:0] lres;
  always_comb begin
    case (opsel)
      4'h0, 4'h8: lres = op_a & op_b;
      4'h1, 4'h9: lres = op_a ^ op_b;
      4'hC:       lres = op_a | op_b;
      4'hD:       lres = op_b;
      4'hE:       lres = op_a & ~op_b;
      default:    lres = ~op_b;
    endcase
  end

  logic [W-1:0] res_c;
  logic         nc, nv;
  assign res_c = arith ? sum[W-1:0] : lres;
  assign nc    = arith ? sum[W] : shift_cy;
  assign nv    = arith ? ((ax[MSB] == ay[MSB]) && (sum[MSB] != ax[MSB])) : fv;

  logic wr_n, fw_n;
  assign wr_n = pass && !flag_only;
  assign fw_n = pass && (flag_only || set_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= 4'h0;
      flags_we  <= 1'b0;
    end else begin
      result    <= wr_n ? res_c : '0;
      result_we <= wr_n;
      flags_we  <= fw_n;
      flags_out <= fw_n ? {res_c[MSB], (res_c == '0), nc, nv} : flags_in;
    end
  end

  AST_FAIL_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |=> (!result_we && !flags_we)); // R2
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_n |=> (flags_out == $past(flags_in))); // R9
  AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && flag_only) |=> (flags_we && !result_we)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !result_we |-> (result == '0)); // R2
  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (result_we && flags_we) |-> (flags_out[3] == result[MSB])); // R7
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (result_we && flags_we) |-> (flags_out[2] == (result == '0))); // R5
  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !arith && !flag_only && set_flags) |=> (flags_out[0] == $past(flags_in[0]))); // R7
endmodule

// File: tb/cond_alu_tb_top.sv
`timescale 1ns/1ps
module cond_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  opsel = '0, cond = '0, flags_in = '0;
  logic        set_flags = 1'b0, shift_cy = 1'b0;
  logic [31:0] result;
  logic        result_we, flags_we;
  logic [3:0]  flags_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cond_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opsel(opsel),
    .cond(cond), .set_flags(set_flags), .flags_in(flags_in), .shift_cy(shift_cy),
    .result(result), .result_we(result_we), .flags_out(flags_out), .flags_we(flags_we)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
      input logic [3:0] op, input logic [3:0] cd, input bit sf, input logic [3:0] fl,
      input bit sc, output logic [31:0] r, output bit rwe, output logic [3:0] fo, output bit fwe);
    bit n = fl[3], z = fl[2], c = fl[1], v = fl[0];
    bit ok, fonly, ar, nc, nv;
    longint ua = a, ub = b, sa = $signed(a), sb = $signed(b), ur, sr, bo;
    case (cd)
      0: ok = z;       1: ok = !z;      2: ok = c;        3: ok = !c;
      4: ok = n;       5: ok = !n;      6: ok = v;        7: ok = !v;
      8: ok = c && !z; 9: ok = !c || z; 10: ok = (n == v); 11: ok = (n != v);
      12: ok = !z && (n == v); 13: ok = z || (n != v); 14: ok = 1; default: ok = 0;
    endcase
    fonly = (op >= 8 && op <= 11);
    ar = 1; bo = c ? 0 : 1; ur = 0; sr = 0; nc = 0;
    case (op)
      2, 10: begin ur = ua - ub;      sr = sa - sb;      nc = (ua >= ub);      end
      6:     begin ur = ua - ub - bo; sr = sa - sb - bo; nc = (ua >= ub + bo); end
      3:     begin ur = ub - ua;      sr = sb - sa;      nc = (ub >= ua);      end
      7:     begin ur = ub - ua - bo; sr = sb - sa - bo; nc = (ub >= ua + bo); end
      4, 11: begin ur = ua + ub;      sr = sa + sb;      nc = (ur >= 64'sd4294967296); end
      5:     begin ur = ua + ub + c;  sr = sa + sb + c;  nc = (ur >= 64'sd4294967296); end
      default: ar = 0;
    endcase
    if (ar) begin
      r = ur[31:0];
      nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (op)
        0, 8: r = a & b;  1, 9: r = a ^ b;  12: r = a | b;
        13: r = b;        14: r = a & ~b;   default: r = ~b;
      endcase
      nc = sc; nv = v;
    end
    fo = {r[31], (r == 0), nc, nv};
    rwe = ok && !fonly;
    fwe = ok && (fonly || sf);
    if (!fwe) fo = fl;
    if (!rwe) r = '0;
  endfunction

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                      input logic [3:0] cd, input bit sf, input logic [3:0] fl,
                      input bit sc, input string tag);
    logic [31:0] er; bit erwe, efwe; logic [3:0] efo;
    op_a = a; op_b = b; opsel = op; cond = cd; set_flags = sf; flags_in = fl; shift_cy = sc;
    model(a, b, op, cd, sf, fl, sc, er, erwe, efo, efwe);
    @(negedge clk);
    chk(result == er,       tag, "result",    result, er);
    chk(result_we == erwe,  tag, "result_we", {31'b0, result_we}, {31'b0, erwe});
    chk(flags_out == efo,   tag, "flags_out", {28'b0, flags_out}, {28'b0, efo});
    chk(flags_we == efwe,   tag, "flags_we",  {31'b0, flags_we}, {31'b0, efwe});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; opsel = 4'h4; cond = 4'hE; set_flags = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs stay zero while reset is held
    chk(result == 0 && !result_we && !flags_we && flags_out == 0, "R10", "reset",
        {result[27:0], result_we, flags_we, flags_out[1:0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5: additions with carry and overflow corners
    step(32'h7FFF_FFFF, 32'h1, 4'h4, 4'hE, 1, 4'h0, 0, "R5");
    step(32'hFFFF_FFFF, 32'h1, 4'h4, 4'hE, 1, 4'h0, 0, "R4");
    step(32'hFFFF_FFFF, 32'h0, 4'h5, 4'hE, 1, 4'h2, 0, "R3");
    step(32'h8000_0000, 32'h8000_0000, 4'h4, 4'hE, 1, 4'h0, 0, "R5");
    // R3 R4: subtract forms, borrow from NOT C
    step(32'd5, 32'd5, 4'h2, 4'hE, 1, 4'h0, 0, "R4");
    step(32'd3, 32'd5, 4'h2, 4'hE, 1, 4'h0, 0, "R4");
    step(32'd5, 32'd5, 4'h6, 4'hE, 1, 4'h0, 0, "R3");
    step(32'd5, 32'd5, 4'h6, 4'hE, 1, 4'h2, 0, "R3");
    step(32'd2, 32'd9, 4'h3, 4'hE, 1, 4'h0, 0, "R3");
    step(32'd9, 32'd9, 4'h7, 4'hE, 1, 4'h0, 0, "R3");
    step(32'h8000_0000, 32'h1, 4'h2, 4'hE, 1, 4'h0, 0, "R5");
    // R6 R7: logical forms take C from shift carry, keep V
    step(32'hF0F0_0000, 32'h0F0F_0000, 4'h0, 4'hE, 1, 4'h1, 1, "R7");
    step(32'hF0F0_1234, 32'hFFFF_0000, 4'hE, 4'hE, 1, 4'h0, 0, "R6");
    step(32'h0, 32'h0, 4'hF, 4'hE, 1, 4'h1, 1, "R7");
    step(32'h1234, 32'h8765_4321, 4'hD, 4'hE, 1, 4'h0, 0, "R6");
    step(32'h00FF, 32'hFF00, 4'hC, 4'hE, 0, 4'h0, 0, "R6");
    step(32'hAAAA, 32'hAAAA, 4'h1, 4'hE, 1, 4'h0, 1, "R6");
    // R8: flag-only forms even with set_flags low
    step(32'd7, 32'd7, 4'hA, 4'hE, 0, 4'h0, 0, "R8");
    step(32'hFFFF_FFFF, 32'h1, 4'hB, 4'hE, 0, 4'h0, 0, "R8");
    step(32'h0F, 32'hF0, 4'h8, 4'hE, 0, 4'h9, 1, "R8");
    step(32'h5, 32'h5, 4'h9, 4'hE, 0, 4'h0, 0, "R8");
    // R9: set_flags low leaves flags unwritten
    step(32'h1, 32'h1, 4'h4, 4'hE, 0, 4'hB, 0, "R9");
    // R2: failing condition squashes, including code 1111
    step(32'h1, 32'h2, 4'h4, 4'h0, 1, 4'h0, 0, "R2");
    step(32'h1, 32'h2, 4'hA, 4'hF, 1, 4'hF, 1, "R2");
    step(32'h3, 32'h3, 4'hD, 4'hF, 1, 4'h0, 0, "R2");

    // R1: every condition code against every flag pattern
    for (int cd = 0; cd < 16; cd++)
      for (int fl = 0; fl < 16; fl++)
        step(32'h10 + cd, 32'h3, 4'h4, cd[3:0], 1, fl[3:0], fl[0], "R1");

    // R11: back-to-back mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++)
      step($urandom, (i % 7 == 0) ? 32'h0 : $urandom, 4'($urandom), 4'($urandom),
           1'($urandom), 4'($urandom), 1'($urandom), "R11");

    summary();
    $finish;
  end
endmodule